// File: doc/BRIEF.md
# Gated Interval Timer Channel

A single 16-bit up-counting timer channel. Software programs it through a small write/read port with three registers: a control word, the live count and a compare value. The count advances on ticks taken from one of three bus-clock prescaler taps or from the rising edges of an external horizontal-blank signal. Counting can be qualified or restarted by a blanking gate, chosen from the horizontal-blank or vertical-blank level inputs.

Two events can interrupt: the count stepping onto the compare value, and the count wrapping from all-ones to zero. Each event sets a sticky status bit that software clears by writing a 1 to it. Each event also drives a one-cycle pulse on `irq` for a downstream interrupt controller. A compare match can optionally pull the count back to zero, which turns the channel into a periodic tick source.

The gate logic is a three-state machine. GS_OFF is the state while gating is disabled. GS_LOW is the state after a low gate sample, and GS_HIGH is the state after a high one. Every clock it moves to GS_OFF when gating is off, and otherwise to GS_HIGH or GS_LOW according to the gate level. A rising edge is the transition GS_LOW to GS_HIGH, and a falling edge is GS_HIGH to GS_LOW. Entering the machine from GS_OFF never counts as an edge.

Top module: `gtimer_chan`

## Requirements
- R1: After reset, the control word, status bits, count and compare value all read zero and `irq` is low.
- R2: Control bit 7 enables the channel. While it is 0, the count and the prescaler hold their values and no gate restart happens.
- R3: Control bits 1:0 pick the tick: 0 means every clock, 1 means every 16th clock, 2 means every 256th clock (from a free prescaler that advances while enabled), and 3 means each rising edge of `hblank`.
- R4: When a tick steps the count onto the compare value and control bit 8 is 1, status bit 10 is set and `irq` pulses on the next cycle.
- R5: A compare match returns the count to zero only when both control bit 6 and bit 8 are 1. Otherwise counting continues past the compare value.
- R6: A tick at count 0xFFFF wraps the count to 0. If control bit 9 is 1, status bit 11 is set and `irq` pulses.
- R7: A control write (select 0) replaces bits 9:0. It clears exactly those status bits 11:10 whose positions hold a 1 in the written data. An event in the same cycle sets its status bit anyway.
- R8: A count write (select 1) loads the data on the next cycle, overrides any tick or gate restart in that cycle and keeps the prescaler phase.
- R9: A compare value (select 2) written at or below the current count does not fire until the count wraps and climbs to it again.
- R10: Control bit 2 enables gating and bit 3 selects the gate (0 = `hblank`, 1 = `vblank`). With gate kind bits 5:4 = 0, ticks are dropped while the gate is high. When bits 3:0 equal 0x7, gating is disabled.
- R11: Gate kinds 1, 2 and 3 zero the count on a gate rising edge, a falling edge, or either edge. Otherwise counting goes on regardless of the level.
- R12: `irq` is high for exactly one cycle per cycle in which a flag-setting event occurs. A compare and a wrap in the same cycle give one pulse.
- R13: `rd_data` is combinational from `rd_sel`: 0 gives status and control as {bits 11:10, bits 9:0}, 1 gives the live count, 2 gives the compare value, and 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 count, 2 compare |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read select |
| rd_data | output | 16 | Read data, same cycle |
| hblank | input | 1 | Horizontal-blank level, tick source and gate |
| vblank | input | 1 | Vertical-blank level, gate |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check several rules on every cycle. The count must hold while the channel is disabled, and a wrap must land on zero. A reload on match must land on zero when both enable bits allow it. A flag must clear on a write of 1, and no interrupt pulse may appear without a status bit. The timing of prescaler ticks, gate edges and restarts, the wait after a compare value written below the count, and the merging of simultaneous events can only be shown by the bench scenarios. The bench compares them cycle by cycle against its behavioural model.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int MODE_W   = 10;
    localparam int FLAG_LSB = 10;

    localparam int MB_RELOAD = 6;
    localparam int MB_RUN    = 7;
    localparam int MB_CMP_IE = 8;
    localparam int MB_OVF_IE = 9;

    localparam logic [1:0] SEL_MODE  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CMP   = 2'd2;

    typedef enum logic [1:0] {
        GS_OFF  = 2'd0,
        GS_LOW  = 2'd1,
        GS_HIGH = 2'd2
    } gate_st_e;

endpackage

// File: rtl/tm_prescale.sv
module tm_prescale #(
    parameter int SLOW_LOG2   = 4,
    parameter int SLOWER_LOG2 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] src,
    input  logic       hblank,
    output logic       tick
);

    logic [SLOWER_LOG2-1:0] pre_q;
    logic                   hb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            hb_q  <= 1'b0;
        end else begin
            hb_q <= hblank;
            if (run) begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (src)
            2'd0:    tick = run;
            2'd1:    tick = run && (&pre_q[SLOW_LOG2-1:0]);
            2'd2:    tick = run && (&pre_q);
            default: tick = run && hblank && !hb_q;
        endcase
    end

endmodule

// File: rtl/tm_gate_fsm.sv
module tm_gate_fsm
    import timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [5:0] gate_mode,
    input  logic       hblank,
    input  logic       vblank,
    output logic       hold,
    output logic       zero_cnt
);

    gate_st_e state_q, state_d;
    logic     gate_on, gate_lvl, rise, fall;
    logic [1:0] kind;

    assign gate_on  = gate_mode[2] && (gate_mode[3:0] != 4'h7);
    assign gate_lvl = gate_mode[3] ? vblank : hblank;
    assign kind     = gate_mode[5:4];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (!gate_on) begin
            state_d = GS_OFF;
        end else if (gate_lvl) begin
            state_d = GS_HIGH;
        end else begin
            state_d = GS_LOW;
        end
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            GS_OFF:  ;
            GS_LOW:  rise = gate_on && gate_lvl;
            GS_HIGH: fall = gate_on && !gate_lvl;
            default: ;
        endcase
        hold = gate_on && (kind == 2'd0) && gate_lvl;
        unique case (kind)
            2'd1:    zero_cnt = run && rise;
            2'd2:    zero_cnt = run && fall;
            2'd3:    zero_cnt = run && (rise || fall);
            default: zero_cnt = 1'b0;
        endcase
    end

endmodule

// File: rtl/tm_core.sv
module tm_core
    import timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold,
    input  logic              zero_cnt,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CW-1:0]     wr_data,
    output logic [CW-1:0]     cnt_q,
    output logic [CW-1:0]     cmp_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [1:0]        flags_q,
    output logic              irq
);

    logic          wr_cnt, wr_mode, wr_cmp;
    logic          step, wrap, evt_cmp, reload, set_cmp, set_ovf;
    logic [CW-1:0] nxt, cnt_d;
    logic [1:0]    flags_d;

    assign wr_cnt  = wr_en && (wr_sel == SEL_COUNT);
    assign wr_mode = wr_en && (wr_sel == SEL_MODE);
    assign wr_cmp  = wr_en && (wr_sel == SEL_CMP);

    assign step    = tick && !hold && !zero_cnt && !wr_cnt;
    assign nxt     = cnt_q + 1'b1;
    assign wrap    = step && (&cnt_q);
    assign evt_cmp = step && (nxt == cmp_q);
    assign reload  = evt_cmp && mode_q[MB_RELOAD] && mode_q[MB_CMP_IE];
    assign set_cmp = evt_cmp && mode_q[MB_CMP_IE];
    assign set_ovf = wrap && mode_q[MB_OVF_IE];

    always_comb begin
        if (wr_cnt) begin
            cnt_d = wr_data;
        end else if (zero_cnt || reload) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = nxt;
        end else begin
            cnt_d = cnt_q;
        end
        flags_d = flags_q;
        if (wr_mode) begin
            flags_d = flags_d & ~wr_data[FLAG_LSB +: 2];
        end
        flags_d = flags_d | {set_ovf, set_cmp};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cmp_q   <= '0;
            mode_q  <= '0;
            flags_q <= '0;
            irq     <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            flags_q <= flags_d;
            irq     <= set_cmp || set_ovf;
            if (wr_mode) begin
                mode_q <= wr_data[MODE_W-1:0];
            end
            if (wr_cmp) begin
                cmp_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/gtimer_chan.sv
module gtimer_chan
    import timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SLOW_LOG2   = 4,
    parameter int SLOWER_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             hblank,
    input  logic             vblank,
    output logic             irq
);

    localparam int PAD_W = CNT_W - MODE_W - 2;

    logic [CNT_W-1:0]  cnt_q, cmp_q;
    logic [MODE_W-1:0] mode_q;
    logic [1:0]        flags_q;
    logic              tick, hold, zero_cnt;

    tm_prescale #(
        .SLOW_LOG2  (SLOW_LOG2),
        .SLOWER_LOG2(SLOWER_LOG2)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mode_q[MB_RUN]),
        .src   (mode_q[1:0]),
        .hblank(hblank),
        .tick  (tick)
    );

    tm_gate_fsm u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mode_q[MB_RUN]),
        .gate_mode(mode_q[5:0]),
        .hblank   (hblank),
        .vblank   (vblank),
        .hold     (hold),
        .zero_cnt (zero_cnt)
    );

    tm_core #(
        .CW(CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .hold    (hold),
        .zero_cnt(zero_cnt),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cnt_q   (cnt_q),
        .cmp_q   (cmp_q),
        .mode_q  (mode_q),
        .flags_q (flags_q),
        .irq     (irq)
    );

    always_comb begin
        unique case (rd_sel)
            2'd0:    rd_data = {{PAD_W{1'b0}}, flags_q, mode_q};
            2'd1:    rd_data = cnt_q;
            2'd2:    rd_data = cmp_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tm_chk.sv
module tm_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic [CW-1:0] wr_data,
    input logic          step,
    input logic          evt_cmp,
    input logic [CW-1:0] cnt_q,
    input logic [9:0]    mode_q,
    input logic [1:0]    flags_q,
    input logic          irq
);

    logic cnt_wr;
    assign cnt_wr = wr_en && (wr_sel == 2'd1);

    // R2
    run_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[7] && !cnt_wr) |=> $stable(cnt_q));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (&cnt_q) && !evt_cmp) |=> (cnt_q == '0));

    // R5
    cmp_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_cmp && mode_q[6] && mode_q[8]) |=> (cnt_q == '0));

    // R4
    cmp_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_cmp && mode_q[8]) |=> (irq && flags_q[0]));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == 2'd0) && wr_data[10] && !evt_cmp) |=> !flags_q[0]);

    // R12
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags_q != 2'b00));

endmodule

bind tm_core tm_chk #(.CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .step   (step),
    .evt_cmp(evt_cmp),
    .cnt_q  (cnt_q),
    .mode_q (mode_q),
    .flags_q(flags_q),
    .irq    (irq)
);

// File: tb/sim_gtimer_chan.sv
`timescale 1ns/1ps
module sim_gtimer_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_sel = 2'd1;
    logic [15:0] rd_data;
    logic        hblank = 1'b0;
    logic        vblank = 1'b0;
    logic        irq;

    int vectors = 0;
    int bad = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    int m_cnt, m_cmp, m_mode, m_fl, m_pre, m_hbq, m_gst, m_irq;
    int en, src, tk, gon, g, gm, rise, fall, hold, zr, wc, wm, wp, stp, wrp, nx, ce, rl;

    always #5 clk = ~clk;

    gtimer_chan u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .hblank(hblank), .vblank(vblank), .irq(irq)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 0; m_mode = 0; m_fl = 0;
            m_pre = 0; m_hbq = 0; m_gst = 0; m_irq = 0;
        end else begin
            en  = (m_mode >> 7) & 1;
            src = m_mode & 3;
            case (src)
                0: tk = en;
                1: tk = en && (m_pre % 16 == 15);
                2: tk = en && (m_pre == 255);
                default: tk = en && hblank && !m_hbq;
            endcase
            gon  = ((m_mode >> 2) & 1) && ((m_mode & 15) != 7);
            g    = ((m_mode >> 3) & 1) ? vblank : hblank;
            gm   = (m_mode >> 4) & 3;
            rise = gon && (m_gst == 1) && g;
            fall = gon && (m_gst == 2) && !g;
            hold = gon && (gm == 0) && g;
            zr   = en && (((gm == 1) && rise) || ((gm == 2) && fall) || ((gm == 3) && (rise || fall)));
            wc = wr_en && wr_sel == 1;
            wm = wr_en && wr_sel == 0;
            wp = wr_en && wr_sel == 2;
            stp = tk && !hold && !zr && !wc;
            wrp = stp && (m_cnt == 65535);
            nx  = (m_cnt + 1) % 65536;
            ce  = stp && (nx == m_cmp);
            rl  = ce && ((m_mode >> 6) & 1) && ((m_mode >> 8) & 1);
            m_irq = (ce && ((m_mode >> 8) & 1)) || (wrp && ((m_mode >> 9) & 1));
            if (wm) m_fl = m_fl & ~((int'(wr_data) >> 10) & 3);
            if (ce && ((m_mode >> 8) & 1)) m_fl = m_fl | 1;
            if (wrp && ((m_mode >> 9) & 1)) m_fl = m_fl | 2;
            if (wc) m_cnt = int'(wr_data);
            else if (zr || rl) m_cnt = 0;
            else if (stp) m_cnt = nx;
            if (wm) m_mode = int'(wr_data) & 1023;
            if (wp) m_cmp = int'(wr_data);
            if (en) m_pre = (m_pre + 1) % 256;
            m_hbq = hblank;
            m_gst = gon ? (g ? 2 : 1) : 0;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        int exp_rd;
        if (chk_on && !done) begin
            case (rd_sel)
                2'd0: exp_rd = (m_fl << 10) | m_mode;
                2'd1: exp_rd = m_cnt;
                2'd2: exp_rd = m_cmp;
                default: exp_rd = 0;
            endcase
            vectors++;
            if (int'(rd_data) != exp_rd || int'(irq) != m_irq) begin
                bad++;
                $display("FAIL %s (R13 read sel %0d): rd_data=%h irq=%0d expected rd_data=%h irq=%0d at %0t",
                         cur_req, rd_sel, rd_data, irq, exp_rd[15:0], m_irq, $time);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic hb_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            hblank = 1'b1; idle(2);
            hblank = 1'b0; idle(3);
        end
    endtask

    task automatic toggle_v(input int n, input int len);
        for (int i = 0; i < n; i++) begin
            vblank = ~vblank; idle(len);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1; chk_on = 1'b1;
        // R1 reset state on every read select
        cur_req = "R1";
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s); idle(2);
        end
        rd_sel = 2'd1;
        // R2 enable and hold; R3 tick sources
        cur_req = "R2";
        wr(2'd0, 16'h0080); idle(20);
        wr(2'd0, 16'h0000); idle(10);
        cur_req = "R3";
        wr(2'd1, 16'h0000); wr(2'd0, 16'h0081); idle(70);
        cur_req = "R2";
        wr(2'd0, 16'h0001); idle(9);
        wr(2'd0, 16'h0081); idle(40);
        cur_req = "R3";
        wr(2'd0, 16'h0082); idle(600);
        wr(2'd0, 16'h0083); hb_pulses(6);
        // R4 compare without reload
        cur_req = "R4";
        wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd2, 16'd12);
        wr(2'd0, 16'h0180); idle(40);
        // R5 reload only with both bits
        cur_req = "R5";
        wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd0, 16'h01C0); idle(40);
        wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd0, 16'h00C0); idle(30);
        // R6 wrap and overflow flag
        cur_req = "R6";
        wr(2'd0, 16'h0000); wr(2'd1, 16'hFFF0); wr(2'd0, 16'h0280); idle(30);
        // R7 write-one-to-clear, per bit
        cur_req = "R7";
        rd_sel = 2'd0;
        wr(2'd0, 16'h0680); idle(3);
        wr(2'd0, 16'h0A80); idle(3);
        wr(2'd2, 16'd1); wr(2'd1, 16'h0000); wr(2'd0, 16'h01C0); idle(4);
        wr(2'd0, 16'h05C0); idle(4);
        rd_sel = 2'd1;
        // R8 count write keeps prescaler phase and wins over ticks
        cur_req = "R8";
        wr(2'd0, 16'h0081); idle(7);
        wr(2'd1, 16'd100); idle(40);
        wr(2'd0, 16'h0080); idle(5);
        wr(2'd1, 16'd7); idle(5);
        // R12 simultaneous compare and wrap merge into one pulse
        cur_req = "R12";
        wr(2'd0, 16'h0000); wr(2'd2, 16'h0000); wr(2'd1, 16'hFFF8);
        wr(2'd0, 16'h0380); idle(20);
        // R10 level gate on hblank, then vblank, then disabled field
        cur_req = "R10";
        wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd0, 16'h0084);
        for (int k = 0; k < 3; k++) begin
            hblank = 1'b1; idle(8); hblank = 1'b0; idle(8);
        end
        wr(2'd0, 16'h008C); toggle_v(6, 8);
        wr(2'd0, 16'h0087); hb_pulses(5);
        // R11 edge restarts on vblank
        cur_req = "R11";
        vblank = 1'b0;
        wr(2'd0, 16'h009C); toggle_v(6, 10);
        wr(2'd0, 16'h00AC); toggle_v(6, 10);
        wr(2'd0, 16'h00BC); toggle_v(6, 10);
        // R13 read selects while counting
        cur_req = "R13";
        wr(2'd2, 16'h1234);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s); idle(3);
        end
        rd_sel = 2'd1;
        // R9 compare at current count waits a full wrap
        cur_req = "R9";
        wr(2'd0, 16'h0000); wr(2'd1, 16'hFFF0); wr(2'd2, 16'hFFF0);
        wr(2'd0, 16'h0180); idle(65545);
        finish_run();
    end

endmodule